// File: doc/BRIEF.md
# Hash Engine Interrupt Controller

This block collects event pulses from a hash accelerator and turns them into interrupt requests. Four sticky status bits record that a new context may be loaded, that a suspended partial result can be read, that the engine can take the next 64-byte input block, and that a result is waiting. Software reads these bits through a small register port and clears them by writing 1 to them. A per-bit enable register and a global enable decide which bits reach the combined interrupt line. A separate partial-hash line depends only on the global enable.

When the engine finishes a context-switch suspend, it also reports whether the result was already final: either the closing hash, or the outer hash of an HMAC. A final result sets output-ready rather than partial-hash-ready, so software never tries to resume a computation that has already completed. A suspend that is not final sets partial-hash-ready.

Top module: `hash_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the status, enable and global-enable registers read 0, and both interrupt outputs are 0.
- R2: A one-cycle pulse on an event input sets its status bit from the next clock edge onward. The bit positions are: context ready = bit 3, partial hash ready = bit 2, input ready = bit 1, output ready = bit 0. Status bits stay set until software clears them.
- R3: A write to address 0 clears each status bit whose data bit is 1 and leaves alone the bits whose data bit is 0.
- R4: If a status bit is written with 1 in the same cycle as an event that sets it, the bit stays set.
- R5: A suspend pulse with the final flag low sets bit 2 and no other bit.
- R6: A suspend pulse with the final flag high sets bit 0 and leaves bit 2 unchanged.
- R7: `irq_combined` goes high one cycle after the global enable is 1 and some status bit is 1 whose enable bit is also 1. Otherwise it is 0 in that cycle.
- R8: `irq_partial` goes high one cycle after the global enable is 1 and status bit 2 is 1. The enable register has no effect on it.
- R9: Address 1 holds the enable register, whose bit positions are the same as the status bits. Bit 0 of address 2 is the global enable, and its upper bits read 0. Address 3 reads 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ev_ctx_ready | input | 1 | Pulse: context input registers are free |
| ev_input_ready | input | 1 | Pulse: engine can take the next data block |
| ev_output_ready | input | 1 | Pulse: result is available |
| ev_suspend | input | 1 | Pulse: context-switch suspend finished |
| ev_suspend_final | input | 1 | Qualifies ev_suspend: the result is already final |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 status, 1 enable, 2 global |
| reg_wdata | input | 4 | Write data |
| reg_rdata | output | 4 | Read data for reg_addr (combinational) |
| irq_combined | output | 1 | Registered, masked OR of the status bits |
| irq_partial | output | 1 | Registered partial-hash interrupt |

## Verification
Most internal faults appear at the ports within one or two cycles. A status bit that fails to stick, fails to clear, or sits at the wrong position shows up on the status readback in the cycle after the event or write. It also changes the interrupt lines one cycle later. A suspend routed to the wrong bit is caught on the first suspend, whether final or not. Masking faults are caught as soon as some pattern of enable bits gives a combined line that disagrees with the expected masked OR. The same holds when a set enable bit changes the partial line.

// File: rtl/hirq_pkg.sv
// Package: shared constants for the hash interrupt controller.
// Assumes four event sources whose status bit positions are fixed by software.
package hirq_pkg;
    localparam int NUM_SRC  = 4;
    localparam int ADDR_W   = 2;
    localparam int BIT_OUT  = 0;
    localparam int BIT_IN   = 1;
    localparam int BIT_PART = 2;
    localparam int BIT_CTX  = 3;
    localparam logic [ADDR_W-1:0] ADDR_STATUS = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_ENABLE = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_GLOBAL = 2'd2;
endpackage

// File: rtl/hirq_event_map.sv
// Event map: turns the engine pulses into one set vector for the status bits.
// A suspend whose result is final is reported as output ready, not partial.
// Assumes the final flag is only meaningful while the suspend pulse is high.
module hirq_event_map
    import hirq_pkg::*;
(
    input  logic               ev_ctx_ready,
    input  logic               ev_input_ready,
    input  logic               ev_output_ready,
    input  logic               ev_suspend,
    input  logic               ev_suspend_final,
    output logic [NUM_SRC-1:0] set_vec
);
    logic susp_done_final;
    logic susp_partial;

    // Split the suspend pulse by whether the result is already final.
    always_comb begin
        susp_done_final = ev_suspend & ev_suspend_final;
        susp_partial    = ev_suspend & ~ev_suspend_final;
    end

    // Place each source on its status bit position.
    always_comb begin
        set_vec           = '0;
        set_vec[BIT_CTX]  = ev_ctx_ready;
        set_vec[BIT_PART] = susp_partial;
        set_vec[BIT_IN]   = ev_input_ready;
        set_vec[BIT_OUT]  = ev_output_ready | susp_done_final;
    end
endmodule

// File: rtl/hirq_status_bank.sv
// Status bank: one sticky bit per source, cleared by writing 1.
// When a set and a clear reach the same bit in one cycle, the set wins.
module hirq_status_bank
    import hirq_pkg::*;
#(
    parameter int WIDTH = NUM_SRC
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_vec,
    input  logic [WIDTH-1:0] clr_vec,
    output logic [WIDTH-1:0] status
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        // Hold the bit, clear it on write-1, and let a new event override the clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                status[g] <= 1'b0;
            else if (set_vec[g])
                status[g] <= 1'b1;
            else if (clr_vec[g])
                status[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/hirq_cfg_regs.sv
// Configuration registers: the per-bit enable mask and the global enable.
// Assumes a single-cycle write strobe that is already decoded by address.
module hirq_cfg_regs
    import hirq_pkg::*;
#(
    parameter int WIDTH = NUM_SRC
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_enable,
    input  logic             wr_global,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] enable_mask,
    output logic             global_en
);
    // Load the enable mask on its write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            enable_mask <= '0;
        else if (wr_enable)
            enable_mask <= wdata;
    end

    // Load the global enable from bit 0 of its write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            global_en <= 1'b0;
        else if (wr_global)
            global_en <= wdata[0];
    end
endmodule

// File: rtl/hirq_out_stage.sv
// Output stage: registered interrupt lines.
// The combined line uses the enable mask. The partial line uses only the global enable.
module hirq_out_stage
    import hirq_pkg::*;
#(
    parameter int WIDTH = NUM_SRC
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] status,
    input  logic [WIDTH-1:0] enable_mask,
    input  logic             global_en,
    output logic             irq_combined,
    output logic             irq_partial
);
    logic any_enabled;

    // Detect whether any enabled status bit is pending.
    always_comb any_enabled = |(status & enable_mask);

    // Register both interrupt lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_combined <= 1'b0;
            irq_partial  <= 1'b0;
        end else begin
            irq_combined <= global_en & any_enabled;
            irq_partial  <= global_en & status[BIT_PART];
        end
    end
endmodule

// File: rtl/hash_irq_ctrl.sv
// Hash interrupt controller top: decodes the register port and ties together
// the event map, status bank, configuration registers and output stage.
// Assumes reads have no side effects, so the read data is a pure address mux.
module hash_irq_ctrl
    import hirq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ev_ctx_ready,
    input  logic               ev_input_ready,
    input  logic               ev_output_ready,
    input  logic               ev_suspend,
    input  logic               ev_suspend_final,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [NUM_SRC-1:0] reg_wdata,
    output logic [NUM_SRC-1:0] reg_rdata,
    output logic               irq_combined,
    output logic               irq_partial
);
    logic [NUM_SRC-1:0] set_vec;
    logic [NUM_SRC-1:0] clr_vec;
    logic [NUM_SRC-1:0] status_q;
    logic [NUM_SRC-1:0] enable_q;
    logic               glb_q;
    logic               wr_enable;
    logic               wr_global;

    // Decode the write strobe by address.
    always_comb begin
        clr_vec   = (reg_wr && reg_addr == ADDR_STATUS) ? reg_wdata : '0;
        wr_enable = reg_wr && reg_addr == ADDR_ENABLE;
        wr_global = reg_wr && reg_addr == ADDR_GLOBAL;
    end

    // Select the read data by address; unmapped addresses read 0.
    always_comb begin
        case (reg_addr)
            ADDR_STATUS: reg_rdata = status_q;
            ADDR_ENABLE: reg_rdata = enable_q;
            ADDR_GLOBAL: reg_rdata = {{(NUM_SRC-1){1'b0}}, glb_q};
            default:     reg_rdata = '0;
        endcase
    end

    hirq_event_map u_map (
        .ev_ctx_ready     (ev_ctx_ready),
        .ev_input_ready   (ev_input_ready),
        .ev_output_ready  (ev_output_ready),
        .ev_suspend       (ev_suspend),
        .ev_suspend_final (ev_suspend_final),
        .set_vec          (set_vec)
    );

    hirq_status_bank #(.WIDTH(NUM_SRC)) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .status  (status_q)
    );

    hirq_cfg_regs #(.WIDTH(NUM_SRC)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_enable   (wr_enable),
        .wr_global   (wr_global),
        .wdata       (reg_wdata),
        .enable_mask (enable_q),
        .global_en   (glb_q)
    );

    hirq_out_stage #(.WIDTH(NUM_SRC)) u_out (
        .clk          (clk),
        .rst_n        (rst_n),
        .status       (status_q),
        .enable_mask  (enable_q),
        .global_en    (glb_q),
        .irq_combined (irq_combined),
        .irq_partial  (irq_partial)
    );
endmodule

// File: rtl/hirq_checker.sv
// Checker: temporal properties of the hash interrupt controller, bound to the top.
module hirq_checker
    import hirq_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               ev_ctx_ready,
    input logic               ev_input_ready,
    input logic               ev_suspend,
    input logic               ev_suspend_final,
    input logic               reg_wr,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [NUM_SRC-1:0] reg_wdata,
    input logic [NUM_SRC-1:0] status_q,
    input logic [NUM_SRC-1:0] enable_q,
    input logic               glb_q,
    input logic               irq_combined,
    input logic               irq_partial
);
    // R2: a context-ready pulse leaves its bit set.
    assert_ctx_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ctx_ready |=> status_q[BIT_CTX]);

    // R3: a write-1 clears the input-ready bit when no event competes.
    assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_STATUS && reg_wdata[BIT_IN] && !ev_input_ready)
        |=> !status_q[BIT_IN]);

    // R4: an event beats a clear in the same cycle.
    assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_input_ready && reg_wr && reg_addr == ADDR_STATUS && reg_wdata[BIT_IN])
        |=> status_q[BIT_IN]);

    // R5: a suspend that is not final sets partial hash ready.
    assert_susp_partial_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_suspend && !ev_suspend_final) |=> status_q[BIT_PART]);

    // R6: a final suspend sets output ready and never partial hash ready.
    assert_susp_final_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_suspend && ev_suspend_final) |=> status_q[BIT_OUT]);
    assert_susp_final_nopart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_suspend && ev_suspend_final && !status_q[BIT_PART]) |=> !status_q[BIT_PART]);

    // R7: a pending enabled bit raises the combined line one cycle later.
    assert_comb_rises_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_q && |(status_q & enable_q)) |=> irq_combined);

    // R8: the partial line ignores the enable mask and follows the global enable.
    assert_part_global_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_q |=> !irq_partial);
    assert_part_mask_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_q && status_q[BIT_PART]) |=> irq_partial);
endmodule

bind hash_irq_ctrl hirq_checker u_hirq_checker (
    .clk              (clk),
    .rst_n            (rst_n),
    .ev_ctx_ready     (ev_ctx_ready),
    .ev_input_ready   (ev_input_ready),
    .ev_suspend       (ev_suspend),
    .ev_suspend_final (ev_suspend_final),
    .reg_wr           (reg_wr),
    .reg_addr         (reg_addr),
    .reg_wdata        (reg_wdata),
    .status_q         (status_q),
    .enable_q         (enable_q),
    .glb_q            (glb_q),
    .irq_combined     (irq_combined),
    .irq_partial      (irq_partial)
);

// File: tb/tb_hash_irq_ctrl.sv
// Bench: directed corner cases plus seeded random traffic, checked against a bench-side model.
module tb_hash_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_ctx_ready = 0, ev_input_ready = 0, ev_output_ready = 0;
    logic       ev_suspend = 0, ev_suspend_final = 0;
    logic       reg_wr = 0;
    logic [1:0] reg_addr = 0;
    logic [3:0] reg_wdata = 0;
    logic [3:0] reg_rdata;
    logic       irq_combined, irq_partial;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic [3:0] m_st, m_en;
    logic       m_glb, m_comb, m_part;

    always #4 clk = ~clk;

    hash_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .ev_ctx_ready(ev_ctx_ready), .ev_input_ready(ev_input_ready),
        .ev_output_ready(ev_output_ready), .ev_suspend(ev_suspend),
        .ev_suspend_final(ev_suspend_final),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_combined(irq_combined), .irq_partial(irq_partial)
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Expected set vector from the bit-position rules (R2, R5, R6).
    function automatic logic [3:0] exp_set(input logic c, s, sf, i, o);
        return {c, s & ~sf, i, o | (s & sf)};
    endfunction

    task automatic read_reg(input logic [1:0] a, output logic [3:0] v);
        reg_wr = 0; reg_addr = a; #1; v = reg_rdata;
    endtask

    // One clock cycle: drive at negedge, update model at posedge, check at next negedge.
    task automatic step(input logic c, s, sf, i, o, w, input logic [1:0] a,
                        input logic [3:0] d, input string req);
        logic [3:0] clr, rd;
        ev_ctx_ready = c; ev_suspend = s; ev_suspend_final = sf;
        ev_input_ready = i; ev_output_ready = o;
        reg_wr = w; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        m_comb = m_glb & |(m_st & m_en);
        m_part = m_glb & m_st[2];
        clr = (w && a == 2'd0) ? d : 4'h0;
        m_st = (m_st & ~clr) | exp_set(c, s, sf, i, o);
        if (w && a == 2'd1) m_en = d;
        if (w && a == 2'd2) m_glb = d[0];
        @(negedge clk);
        ev_ctx_ready = 0; ev_suspend = 0; ev_suspend_final = 0;
        ev_input_ready = 0; ev_output_ready = 0;
        check({req, " R7 combined"}, {3'b0, irq_combined}, {3'b0, m_comb});
        check({req, " R8 partial"}, {3'b0, irq_partial}, {3'b0, m_part});
        read_reg(2'd0, rd);
        check({req, " R2 status"}, rd, m_st);
    endtask

    task automatic idle(input string req);
        step(0, 0, 0, 0, 0, 0, 2'd0, 4'h0, req);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [3:0] rd;
        void'($urandom(32'h5EED_1234));
        m_st = 0; m_en = 0; m_glb = 0; m_comb = 0; m_part = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        read_reg(2'd0, rd); check("R1 status", rd, 4'h0);
        read_reg(2'd1, rd); check("R1 enable", rd, 4'h0);
        read_reg(2'd2, rd); check("R1 global", rd, 4'h0);
        check("R1 irq", {2'b0, irq_combined, irq_partial}, 4'h0);

        // R2: each source sets its own bit; bits stick
        step(1, 0, 0, 0, 0, 0, 2'd0, 4'h0, "R2 ctx");
        step(0, 0, 0, 1, 0, 0, 2'd0, 4'h0, "R2 in");
        step(0, 0, 0, 0, 1, 0, 2'd0, 4'h0, "R2 out");
        idle("R2 hold");
        // R3: clear only bit 1
        step(0, 0, 0, 0, 0, 1, 2'd0, 4'h2, "R3 w1c");
        step(0, 0, 0, 0, 0, 1, 2'd0, 4'hF, "R3 clear all");
        // R5: non-final suspend
        step(0, 1, 0, 0, 0, 0, 2'd0, 4'h0, "R5 suspend");
        read_reg(2'd0, rd); check("R5 only bit2", rd, 4'h4);
        step(0, 0, 0, 0, 0, 1, 2'd0, 4'hF, "R5 clear");
        // R6: final suspend gives output ready
        step(0, 1, 1, 0, 0, 0, 2'd0, 4'h0, "R6 final");
        read_reg(2'd0, rd); check("R6 only bit0", rd, 4'h1);
        // R4: set beats clear
        step(0, 0, 0, 1, 0, 1, 2'd0, 4'h2, "R4 set wins");
        read_reg(2'd0, rd); check("R4 bit1 kept", rd, 4'h3);
        // R9: config readback and address 3
        step(0, 0, 0, 0, 0, 1, 2'd1, 4'h5, "R9 enable wr");
        read_reg(2'd1, rd); check("R9 enable", rd, 4'h5);
        step(0, 0, 0, 0, 0, 1, 2'd3, 4'hF, "R9 addr3 wr");
        read_reg(2'd3, rd); check("R9 addr3", rd, 4'h0);
        read_reg(2'd1, rd); check("R9 enable kept", rd, 4'h5);
        read_reg(2'd2, rd); check("R9 global kept", rd, 4'h0);
        // R8: partial ignores mask (enable bit 2 cleared)
        step(0, 0, 0, 0, 0, 1, 2'd1, 4'h0, "R8 mask off");
        step(0, 0, 0, 0, 0, 1, 2'd2, 4'hF, "R8 global on");
        read_reg(2'd2, rd); check("R9 global", rd, 4'h1);
        step(0, 1, 0, 0, 0, 0, 2'd0, 4'h0, "R8 suspend");
        idle("R8 partial up");
        check("R8 partial unmasked", {3'b0, irq_partial}, 4'h1);
        check("R7 combined masked", {3'b0, irq_combined}, 4'h0);
        step(0, 0, 0, 0, 0, 1, 2'd1, 4'h1, "R7 enable out");
        idle("R7 combined up");
        check("R7 combined", {3'b0, irq_combined}, 4'h1);

        // Random traffic
        for (int k = 0; k < 3000; k++) begin
            logic w;
            logic [1:0] a;
            w = ($urandom % 4) == 0;
            a = 2'($urandom % 4);
            if (a == 2'd0 && ($urandom % 2)) a = 2'd0;
            step(($urandom % 5) == 0, ($urandom % 6) == 0, $urandom % 2,
                 ($urandom % 5) == 0, ($urandom % 5) == 0,
                 w, a, 4'($urandom), "random");
        end
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule